// File: doc/BRIEF.md
# Seven-Bit Downcounting Watchdog

This block is the supervision timer of a small microcontroller. One 8-bit control word holds a one-way arm bit in bit 7 and a 7-bit down-counter in bits 6..0. The counter steps down once per prescaler period of `PRESCALE` CPU clocks (12288 by default). Once armed, the block asks for a system reset when counter bit 6 falls to zero. Software keeps the chip alive by rewriting the control word with a value whose bit 6 is set; bits 5..0 choose how many steps remain.

A reset request also comes from three other sources: a write that arms the block with bit 6 clear, which is the software reset; any write with bit 6 clear once the block is armed; and a halt-entry strobe while the block is armed. When the block is not armed, the counter runs as a free 7-bit timer that software can read, and it never requests a reset. A status flag records that the watchdog caused the last reset. The flag survives that reset and is cleared by an ordinary reset or by software.

Top module: `wdt7_guard`

## Requirements
- R1: After `rst` the control word reads 7Fh (arm bit 0, count 7Fh), the status word reads 00h, and `wdg_reset_req` is low.
- R2: Once a control write sets bit 7, later writes with bit 7 clear leave the arm bit at 1 until `rst`.
- R3: While armed, a request is raised when a counter step takes the count from 40h to 3Fh, so a reload value with bits 5..0 = n requests after n+1 steps.
- R4: A control write loads bits 6..0 into the counter and restarts the prescaler, so the next step comes exactly `PRESCALE` cycles after the write.
- R5: A control write with bit 6 = 0 raises a request when bit 7 of the write is 1 or the block is already armed.
- R6: A `halt_enter` strobe raises a request while armed and has no effect while not armed.
- R7: While not armed the counter keeps stepping, wraps from 00h to 7Fh, and never raises a request.
- R8: Each request event gives `wdg_reset_req` high for one cycle, in the cycle right after the event's clock edge.
- R9: Status bit 0 is set together with a request, keeps its value across the first `rst` that follows the request, and is cleared by any later `rst`.
- R10: Writing the status word with bit 0 = 0 clears the flag, and writing bit 0 = 1 leaves it unchanged.
- R11: Reads return data one cycle after `bus_rd`. `bus_sel` = 0 selects the control word ({arm, count}) and `bus_sel` = 1 selects the status word (flag in bit 0, other bits 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| halt_enter | input | 1 | Halt-entry strobe from the CPU |
| wdg_reset_req | output | 1 | Registered one-cycle reset request |

## Verification
A request caused by a write or a halt strobe shows on `wdg_reset_req` one clock after the edge that samples the strobe. A timeout request shows exactly (n+1)·`PRESCALE` edges after the reload edge, and read data shows one edge after the read strobe. The bench drives all inputs on falling edges and samples on falling edges. It counts falling edges from the reload edge up to the first high request and compares that count with the computed figure. For count readback it places the read strobe a known number of edges after reset or reload, so that the expected count follows from the step arithmetic.

// File: rtl/wdt7_pkg.sv
package wdt7_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 7;
  // counter value whose next step clears bit 6
  localparam logic [CNT_W-1:0] CNT_TRIP  = 7'h40;
  localparam logic [CNT_W-1:0] CNT_RESET = 7'h7F;
  typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} wdt_sel_e;
endpackage

// File: rtl/wdt7_prescaler.sv
module wdt7_prescaler #(
  parameter int unsigned DIV = 12288
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = ~restart;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      assign tick = (pre_q == LAST);

      always_ff @(posedge clk) begin
        if (rst || restart)  pre_q <= '0;
        else if (tick)       pre_q <= '0;
        else                 pre_q <= pre_q + 1'b1;
      end

      // R4: divider phase never leaves its range
      p_pre_range_r4: assert property (@(posedge clk) disable iff (rst)
        pre_q <= LAST);
      // R4: a restart puts the phase back to zero
      p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        restart |=> pre_q == '0);
    end
  endgenerate
endmodule

// File: rtl/wdt7_core.sv
module wdt7_core
  import wdt7_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              halt,
  output logic              en_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              fire
);
  logic new_en, wr_fire, tick_fire, halt_fire;

  assign new_en    = en_q | wdata[DATA_W-1];
  assign wr_fire   = wr_ctrl & new_en & ~wdata[CNT_W-1];
  assign tick_fire = ~wr_ctrl & tick & en_q & (cnt_q == CNT_TRIP);
  assign halt_fire = halt & en_q;
  assign fire      = wr_fire | tick_fire | halt_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      cnt_q <= CNT_RESET;
    end else if (wr_ctrl) begin
      en_q  <= new_en;
      cnt_q <= wdata[CNT_W-1:0];
    end else if (tick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R2: arm bit is one-way
  p_arm_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    en_q |=> en_q);
  // R3/R7: a step without a write lowers the count by one
  p_step_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_ctrl) |=> cnt_q == $past(cnt_q) - 7'd1);
  // R4: a write loads the count field
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> cnt_q == $past(wdata[CNT_W-1:0]));
endmodule

// File: rtl/wdt7_status.sv
module wdt7_status (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic wr_stat,
  input  logic wbit,
  output logic flag_q
);
  logic cause_q;

  always_ff @(posedge clk) begin
    if (rst)       cause_q <= 1'b0;
    else if (fire) cause_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 flag_q <= cause_q;
    else if (fire)           flag_q <= 1'b1;
    else if (wr_stat && !wbit) flag_q <= 1'b0;
  end

  // R9: flag follows every request
  p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
    fire |=> flag_q);
  // R10: software clear takes effect when no request competes
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !wbit && !fire) |=> !flag_q);
  // R10: writing one cannot raise the flag
  p_flag_noset_r10: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !fire) |=> !flag_q);
endmodule

// File: rtl/wdt7_readback.sv
module wdt7_readback
  import wdt7_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              sel,
  input  logic              en,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= (wdt_sel_e'(sel) == SEL_STAT) ? {{(DATA_W-1){1'b0}}, flag}
                                             : {en, cnt};
  end

  // R11: status reads carry only bit 0
  p_stat_width_r11: assert property (@(posedge clk) disable iff (rst)
    (rd && sel) |=> rdata[DATA_W-1:1] == '0);
endmodule

// File: rtl/wdt7_guard.sv
module wdt7_guard
  import wdt7_pkg::*;
#(
  parameter int unsigned PRESCALE = 12288
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              halt_enter,
  output logic              wdg_reset_req
);
  logic wr_ctrl, wr_stat, tick, fire, en_q, flag_q;
  logic [CNT_W-1:0] cnt_q;

  assign wr_ctrl = bus_wr & (wdt_sel_e'(bus_sel) == SEL_CTRL);
  assign wr_stat = bus_wr & (wdt_sel_e'(bus_sel) == SEL_STAT);

  wdt7_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .restart(wr_ctrl), .tick(tick)
  );

  wdt7_core u_core (
    .clk(clk), .rst(rst), .tick(tick), .wr_ctrl(wr_ctrl),
    .wdata(bus_wdata), .halt(halt_enter),
    .en_q(en_q), .cnt_q(cnt_q), .fire(fire)
  );

  wdt7_status u_stat (
    .clk(clk), .rst(rst), .fire(fire), .wr_stat(wr_stat),
    .wbit(bus_wdata[0]), .flag_q(flag_q)
  );

  wdt7_readback u_rb (
    .clk(clk), .rst(rst), .rd(bus_rd), .sel(bus_sel),
    .en(en_q), .cnt(cnt_q), .flag(flag_q), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) wdg_reset_req <= 1'b0;
    else     wdg_reset_req <= fire;
  end

  // R7: no request while the block is not armed
  p_req_armed_r7: assert property (@(posedge clk) disable iff (rst)
    wdg_reset_req |-> en_q);
  // R9: the status flag is up whenever a request is out
  p_req_flag_r9: assert property (@(posedge clk) disable iff (rst)
    wdg_reset_req |-> flag_q);
endmodule

// File: tb/wdt7_guard_test.sv
`timescale 1ns/1ps
module wdt7_guard_test;
  localparam int P = 8;
  localparam int NV = 4;
  localparam logic [7:0] VEC_LOAD [NV] = '{8'hC0, 8'hC1, 8'hCF, 8'hFF};
  localparam int         VEC_STEP [NV] = '{1, 2, 16, 64};

  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
  logic halt_enter = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic wdg_reset_req;
  int n_cmp = 0, n_bad = 0, req_seen = 0;

  always #10 clk = ~clk;

  wdt7_guard #(.PRESCALE(P)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .halt_enter(halt_enter),
    .wdg_reset_req(wdg_reset_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output int v);
    @(negedge clk); bus_rd = 1'b1; bus_sel = sel;
    @(negedge clk); bus_rd = 1'b0; v = int'(bus_rdata);
  endtask

  task automatic halt_pulse();
    @(negedge clk); halt_enter = 1'b1;
    @(negedge clk); halt_enter = 1'b0;
  endtask

  task automatic wait_watch(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdg_reset_req) req_seen++;
    end
  endtask

  task automatic edges_to_req(output int k);
    k = 0;
    while (!wdg_reset_req && k < 5000) begin
      @(negedge clk); k++;
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v, k;
    do_reset();
    // R1 and R11: reset contents and readback layout
    check("R1 no request", int'(wdg_reset_req), 0);
    rd(1'b0, v); check("R1 ctrl", v, 8'h7F);
    rd(1'b1, v); check("R11 stat", v, 8'h00);

    // R3/R8: reload table, steps until request
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(1'b0, VEC_LOAD[i]);
      edges_to_req(k);
      check("R3 timeout edges", k, VEC_STEP[i] * P);
      @(negedge clk);
      check("R8 one-cycle pulse", int'(wdg_reset_req), 0);
    end

    // R4: a reload restarts the prescaler
    do_reset();
    wr(1'b0, 8'hC5);
    wait_watch(P / 2);
    wr(1'b0, 8'hC5);
    edges_to_req(k);
    check("R4 prescaler restart", k, 6 * P);

    // R4: count readback after two steps
    do_reset();
    wr(1'b0, 8'hD0);
    wait_watch(2 * P + 2);
    rd(1'b0, v); check("R4 count after steps", v, 8'hCE);

    // R2: arm bit cannot be cleared
    do_reset();
    wr(1'b0, 8'hFF);
    wr(1'b0, 8'h7F);
    check("R2 no request on bit6 set", int'(wdg_reset_req), 0);
    rd(1'b0, v); check("R2 arm kept", v, 8'hFF);

    // R5: software reset variants
    do_reset();
    wr(1'b0, 8'h80);
    check("R5 arm with bit6 clear", int'(wdg_reset_req), 1);
    do_reset();
    wr(1'b0, 8'hFF);
    wr(1'b0, 8'h3F);
    check("R5 armed write bit6 clear", int'(wdg_reset_req), 1);
    do_reset();
    wr(1'b0, 8'h3F);
    check("R5 unarmed write bit6 clear", int'(wdg_reset_req), 0);

    // R6: halt strobe
    do_reset();
    halt_pulse();
    check("R6 halt unarmed ignored", int'(wdg_reset_req), 0);
    rd(1'b1, v); check("R6 flag untouched", v, 0);
    wr(1'b0, 8'hFF);
    halt_pulse();
    check("R6 halt armed", int'(wdg_reset_req), 1);

    // R9: flag survives the watchdog reset, cleared by the next
    rd(1'b1, v); check("R9 flag set", v, 1);
    do_reset();
    rd(1'b1, v); check("R9 flag after wdg reset", v, 1);
    do_reset();
    rd(1'b1, v); check("R9 flag after plain reset", v, 0);

    // R10: software clear of the flag
    wr(1'b0, 8'h80);
    wr(1'b1, 8'h01);
    rd(1'b1, v); check("R10 write one keeps", v, 1);
    wr(1'b1, 8'h00);
    rd(1'b1, v); check("R10 write zero clears", v, 0);

    // R7: free-running timer with wrap and no request
    do_reset();
    req_seen = 0;
    wait_watch(70 * P + 2);
    rd(1'b0, v); check("R7 free count", v, 8'h39);
    wait_watch(60 * P);
    rd(1'b0, v); check("R7 wrap count", v, 8'h7D);
    check("R7 no request", req_seen, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule